// File: doc/BRIEF.md
# Node Latency Alignment Delay

This block sits in every leaf of a tree-shaped timing network. It lines up the clock-enable and data streams of all nodes so that each one has the same total latency from the root. A node learns its own round-trip loop time from an external time measurement and presents it on a strobed input. The block takes half of that loop time as the node's one-way link latency. It is also given the longest one-way latency found anywhere in the tree. The block pads the difference between the two with its own delay.

The padding is split into two parts. The first is a coarse part, counted in whole clock cycles of the user clock. The second is a fine residue, counted in 10 ps units, which is passed out for an external fine delay element. The coarse part is realised as a circular buffer whose read pointer trails the write pointer by the coarse setting. A computed setting only takes effect on a load strobe. The output valid flag drops while the delay line refills after a load. A required coarse delay larger than the buffer can hold is clamped, and this is flagged.

Top module: `lat_align_delay`

## Requirements
- R1: While reset is high and just after it, `coarse_out`, `fine_out`, `out_of_range`, `dout`, `dout_en` and `dout_vld` are all 0.
- R2: On a clock edge where `loop_vld` is 1, the node's own latency becomes floor(`loop_time` / 2). A `loop_time` value presented while `loop_vld` is 0 has no effect on the settings produced by a later load.
- R3: When `max_lat` exceeds the own latency, the difference in 10 ps units is split: `coarse_out` becomes floor(difference / STEP_UNITS) and `fine_out` becomes the remainder. When `max_lat` is at or below the own latency, both become 0.
- R4: If the coarse count would exceed 2^PTR_W − 1, `coarse_out` is clamped to 2^PTR_W − 1, `fine_out` becomes 0 and `out_of_range` becomes 1. A later in-range load clears `out_of_range`.
- R5: `coarse_out`, `fine_out` and `out_of_range` change only on an edge where `load` is 1. Changes to `max_lat` or `loop_time` without a load leave them, and the data delay, untouched.
- R6: With coarse setting C in force, the `din`/`din_en` pair sampled at edge n appears on `dout`/`dout_en` after edge n + C. C = 0 gives a single register stage.
- R7: After a load edge L that sets coarse value C, `dout_vld` is 0 after edges L through L + C and is 1 from edge L + C + 1 on. While `dout_vld` is 0, `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_vld | input | 1 | Strobe: `loop_time` holds a new measurement |
| loop_time | input | TIME_W | Measured round-trip time, 10 ps units |
| max_lat | input | TIME_W | Longest one-way latency in the tree, 10 ps units |
| load | input | 1 | Apply the computed delay setting |
| din | input | DATA_W | User data in |
| din_en | input | 1 | Clock-enable bit travelling with the data |
| dout | output | DATA_W | Delayed user data |
| dout_en | output | 1 | Delayed clock-enable, forced low while invalid |
| dout_vld | output | 1 | Delay line holds a consistent stream |
| coarse_out | output | PTR_W | Coarse delay in force, clock cycles |
| fine_out | output | FINE_W | Fine residue for the external delay element, 10 ps units |
| out_of_range | output | 1 | Coarse delay was clamped |

## Verification
The hardest case to reach is a coarse step sitting exactly at the clamp edge, with a residue just below or just at a full step. Reaching it needs the difference between the broadcast maximum and half of a measured loop to land on precise values. The bench therefore runs a small configuration with 16 buffer entries and 10-unit steps. In that setup a sweep of loop times against several maxima crosses the 159/160 boundary, and a second sweep walks every coarse value from 0 to 15, checking the refill window and the data delay for each.

// File: rtl/lad_pkg.sv
package lad_pkg;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_TIME_W = 24;
  localparam int unsigned DEF_PTR_W  = 8;
  localparam int unsigned DEF_STEP   = 1000;
  localparam int unsigned DEF_FINE_W = 11;
endpackage

// File: rtl/lat_calc.sv
// Captures own latency from a strobed loop time and computes the pending
// coarse/fine split against the tree-wide maximum.
module lat_calc import lad_pkg::*; #(
  parameter int unsigned TIME_W = DEF_TIME_W,
  parameter int unsigned PTR_W  = DEF_PTR_W,
  parameter int unsigned STEP   = DEF_STEP,
  parameter int unsigned FINE_W = DEF_FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loop_vld,
  input  logic [TIME_W-1:0] loop_time,
  input  logic [TIME_W-1:0] max_lat,
  output logic [PTR_W-1:0]  pend_coarse,
  output logic [FINE_W-1:0] pend_fine,
  output logic              pend_oor
);
  localparam logic [TIME_W-1:0] STEP_T = TIME_W'(STEP);
  localparam logic [TIME_W-1:0] CMAX_T = TIME_W'(2**PTR_W - 1);

  logic [TIME_W-1:0] own_lat;
  logic [TIME_W-1:0] diff;
  logic [TIME_W-1:0] quot;

  always_ff @(posedge clk) begin
    if (rst)           own_lat <= '0;
    else if (loop_vld) own_lat <= loop_time >> 1;
  end

  always_comb begin
    diff = (max_lat > own_lat) ? (max_lat - own_lat) : '0;
    quot = diff / STEP_T;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_coarse <= '0;
      pend_fine   <= '0;
      pend_oor    <= 1'b0;
    end else if (quot > CMAX_T) begin
      pend_coarse <= '1;
      pend_fine   <= '0;
      pend_oor    <= 1'b1;
    end else begin
      pend_coarse <= PTR_W'(quot);
      pend_fine   <= FINE_W'(diff % STEP_T);
      pend_oor    <= 1'b0;
    end
  end

  p_own_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(loop_vld)) |-> $stable(own_lat));

  p_fine_range_r3: assert property (@(posedge clk) disable iff (rst)
    pend_fine < FINE_W'(STEP));
endmodule

// File: rtl/refill_ctl.sv
// Blanks the output for the refill window that follows a load.
module refill_ctl import lad_pkg::*; #(
  parameter int unsigned PTR_W = DEF_PTR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PTR_W-1:0] new_coarse,
  output logic             valid_in
);
  logic [PTR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= new_coarse;
    else if (cnt != '0)  cnt <= cnt - PTR_W'(1);
  end

  assign valid_in = !load && (cnt == '0);

  p_count_down_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && ($past(cnt) != '0)) |-> (cnt == $past(cnt) - PTR_W'(1)));
endmodule

// File: rtl/ring_delay.sv
// Circular buffer delay line; read pointer trails write pointer by coarse.
module ring_delay import lad_pkg::*; #(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned PTR_W  = DEF_PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              din_en,
  input  logic [PTR_W-1:0]  coarse,
  input  logic              valid_in,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              dout_vld
);
  localparam int unsigned DEPTH = 2**PTR_W;
  localparam int unsigned WORD_W = DATA_W + 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic [WORD_W-1:0] word;

  assign rd_ptr = wr_ptr - coarse;

  always_ff @(posedge clk) begin
    mem[wr_ptr] <= {din_en, din};
  end

  always_comb begin
    if (coarse == '0) word = {din_en, din};
    else              word = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      dout     <= '0;
      dout_en  <= 1'b0;
      dout_vld <= 1'b0;
    end else begin
      wr_ptr   <= wr_ptr + PTR_W'(1);
      dout     <= word[DATA_W-1:0];
      dout_en  <= word[DATA_W] & valid_in;
      dout_vld <= valid_in;
    end
  end

  p_ptr_advance_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (wr_ptr == $past(wr_ptr) + PTR_W'(1)));
endmodule

// File: rtl/lat_align_delay.sv
module lat_align_delay import lad_pkg::*; #(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned TIME_W = DEF_TIME_W,
  parameter int unsigned PTR_W  = DEF_PTR_W,
  parameter int unsigned STEP   = DEF_STEP,
  parameter int unsigned FINE_W = DEF_FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loop_vld,
  input  logic [TIME_W-1:0] loop_time,
  input  logic [TIME_W-1:0] max_lat,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              din_en,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              dout_vld,
  output logic [PTR_W-1:0]  coarse_out,
  output logic [FINE_W-1:0] fine_out,
  output logic              out_of_range
);
  localparam logic [PTR_W-1:0] CMAX = PTR_W'(2**PTR_W - 1);

  logic [PTR_W-1:0]  pend_coarse;
  logic [FINE_W-1:0] pend_fine;
  logic              pend_oor;
  logic              valid_in;

  lat_calc #(.TIME_W(TIME_W), .PTR_W(PTR_W), .STEP(STEP), .FINE_W(FINE_W)) u_calc (
    .clk(clk), .rst(rst), .loop_vld(loop_vld), .loop_time(loop_time),
    .max_lat(max_lat), .pend_coarse(pend_coarse), .pend_fine(pend_fine),
    .pend_oor(pend_oor)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_out   <= '0;
      fine_out     <= '0;
      out_of_range <= 1'b0;
    end else if (load) begin
      coarse_out   <= pend_coarse;
      fine_out     <= pend_fine;
      out_of_range <= pend_oor;
    end
  end

  refill_ctl #(.PTR_W(PTR_W)) u_refill (
    .clk(clk), .rst(rst), .load(load), .new_coarse(pend_coarse), .valid_in(valid_in)
  );

  ring_delay #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ring (
    .clk(clk), .rst(rst), .din(din), .din_en(din_en), .coarse(coarse_out),
    .valid_in(valid_in), .dout(dout), .dout_en(dout_en), .dout_vld(dout_vld)
  );

  p_settle_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |->
      ($stable(coarse_out) && $stable(fine_out) && $stable(out_of_range)));

  p_sat_flag_r4: assert property (@(posedge clk) disable iff (rst)
    out_of_range |-> (coarse_out == CMAX && fine_out == '0));

  p_load_blanks_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> !dout_vld);
endmodule

// File: tb/lat_align_delay_bench.sv
`timescale 1ns/1ps
module lat_align_delay_bench;
  localparam int DW = 8, TW = 12, PW = 4, ST = 10, FW = 4;
  localparam int CMAX = 15;

  logic clk = 1'b0, rst = 1'b1, loop_vld = 1'b0, load = 1'b0, din_en = 1'b0;
  logic [TW-1:0] loop_time = '0, max_lat = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, dout_vld, out_of_range;
  logic [PW-1:0] coarse_out;
  logic [FW-1:0] fine_out;

  int checks = 0, errors = 0, ecount = 0;
  int own_exp = 0, c_exp = 0, f_exp = 0, o_exp = 0;

  lat_align_delay #(.DATA_W(DW), .TIME_W(TW), .PTR_W(PW), .STEP(ST), .FINE_W(FW)) u_lat_align_delay (
    .clk(clk), .rst(rst), .loop_vld(loop_vld), .loop_time(loop_time), .max_lat(max_lat),
    .load(load), .din(din), .din_en(din_en), .dout(dout), .dout_en(dout_en),
    .dout_vld(dout_vld), .coarse_out(coarse_out), .fine_out(fine_out),
    .out_of_range(out_of_range)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) ecount <= ecount + 1;

  function automatic logic [DW-1:0] fdat(int n);
    return DW'(n * 7 + 3);
  endfunction
  function automatic logic fen(int n);
    return (n % 3) != 0;
  endfunction

  initial forever begin
    @(negedge clk);
    din    = fdat(ecount + 1);
    din_en = fen(ecount + 1);
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_data(string req);
    chk(dout == fdat(ecount - c_exp), req, int'(dout), int'(fdat(ecount - c_exp)));
    chk(dout_en == fen(ecount - c_exp), req, int'(dout_en), int'(fen(ecount - c_exp)));
  endtask

  // R3 R4 expected split
  task automatic model(int maxl);
    int diff;
    diff = (maxl > own_exp) ? maxl - own_exp : 0;
    c_exp = diff / ST; f_exp = diff % ST; o_exp = 0;
    if (c_exp > CMAX) begin c_exp = CMAX; f_exp = 0; o_exp = 1; end
  endtask

  task automatic run_case(int lt, int maxl, bit use_vld);
    @(negedge clk);
    loop_time = TW'(lt); max_lat = TW'(maxl); loop_vld = use_vld;
    if (use_vld) own_exp = lt / 2;
    model(maxl);
    @(negedge clk); loop_vld = 1'b0;
    @(negedge clk);
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    chk(int'(coarse_out) == c_exp, "R3/R4 coarse", int'(coarse_out), c_exp);
    chk(int'(fine_out) == f_exp, "R3/R4 fine", int'(fine_out), f_exp);
    chk(int'(out_of_range) == o_exp, "R4 flag", int'(out_of_range), o_exp);
    chk(dout_vld == 1'b0, "R7 blank at load", int'(dout_vld), 0);
    for (int k = 1; k <= c_exp + 3; k++) begin
      @(negedge clk);
      if (k <= c_exp) begin
        chk(dout_vld == 1'b0, "R7 refill low", int'(dout_vld), 0);
        chk(dout_en == 1'b0, "R7 en gated", int'(dout_en), 0);
      end else begin
        chk(dout_vld == 1'b1, "R7 valid again", int'(dout_vld), 1);
        chk_data("R6 delay");
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(dout_vld == 0 && dout_en == 0 && dout == 0, "R1 outputs", int'(dout), 0);
    chk(coarse_out == 0 && fine_out == 0 && out_of_range == 0, "R1 settings", int'(coarse_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dout_vld == 1'b1, "R7 valid after reset", int'(dout_vld), 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk_data("R6 zero delay");
    end

    // R6 R7 every coarse value
    for (int c = 0; c <= CMAX; c++) run_case(40, 20 + c * ST + 3, 1'b1);

    // R3 R4 sweep across boundary
    for (int lt = 0; lt <= 300; lt += 7) begin
      run_case(lt, 0, 1'b1);
      run_case(lt, 60, 1'b1);
      run_case(lt, 95, 1'b1);
      run_case(lt, 200, 1'b1);
    end
    run_case(0, 159, 1'b1);   // R3 last in-range value: 15, 9
    run_case(0, 160, 1'b1);   // R4 first clamped value
    run_case(40, 4095, 1'b1); // R4 far out of range
    run_case(40, 50, 1'b1);   // R4 flag clears

    // R2 loop time without strobe is ignored
    run_case(300, 100, 1'b0);
    chk(int'(coarse_out) == 8, "R2 ignored loop", int'(coarse_out), 8);

    // R5 no load: inputs change, settings and delay hold
    @(negedge clk);
    max_lat = TW'(3000); loop_time = TW'(2);
    loop_vld = 1'b1;
    @(negedge clk); loop_vld = 1'b0;
    own_exp = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(int'(coarse_out) == 8 && int'(fine_out) == 0 && out_of_range == 0,
          "R5 hold settings", int'(coarse_out), 8);
      chk(dout_vld == 1'b1, "R5 stays valid", int'(dout_vld), 1);
      chk_data("R5 delay held");
    end
    run_case(2, 3000, 1'b0);  // R5 then load applies it

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule